// File: doc/BRIEF.md
# Strided Gap-Skipping Copy Engine

This engine moves a block of data from one region of memory to another in whole 16-byte beats over a 128-bit memory port. Each side has its own line length and skip gap, so a sub-rectangle can be lifted out of one buffer and dropped into another buffer with a different pitch. The engine reads one beat at the source cursor and writes that beat at the destination cursor. After each write it advances both cursors. When a side has finished a line of its programmed width, that side's cursor jumps over its gap. The engine stops once the programmed byte total has been written. Bytes that are skipped over never count toward that total.

Configuration arrives on plain input pins and is latched when `start` is accepted. Line widths and gaps are given in 16-byte units. The gap-enable pin chooses between strided mode and a purely contiguous copy. A configuration that would stall the engine is refused: the engine flags an error and completes at once, with no memory traffic.

All three memory channels use valid/ready handshakes: read request, read data and write. Once the engine raises a valid, it keeps that valid high with a steady payload until the matching ready is seen. The engine holds `rd_rready` high for as long as it waits for read data. The memory side may stall any channel for any number of cycles. Only one read is ever outstanding.

Top module: `strided_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `irq`, `rd_valid` and `wr_valid` are all low.
- R2: A `start` pulse while idle makes `busy` high on the next cycle for a valid configuration. A `start` pulse while `busy` is high is ignored, and the running copy finishes with its original settings.
- R3: The number of beats read and written equals `cfg_size` divided by 16. The low four bits of `cfg_size` are ignored, and skipped gap bytes are not counted.
- R4: With `cfg_gap_en` = 0, the k-th read address is src + 16k and the k-th write address is dst + 16k, whatever the width and gap pins hold.
- R5: With `cfg_gap_en` = 1, the k-th read address is src + 16*((k div W)*(W+G) + (k mod W)), where W = `cfg_in_width` and G = `cfg_in_gap`.
- R6: With `cfg_gap_en` = 1, write addresses follow the same rule as R5 using `cfg_out_width` and `cfg_out_gap`, independently of the input side.
- R7: The k-th written beat carries exactly the data returned for the k-th read.
- R8: The configuration is rejected in three cases: contiguous mode with `cfg_size` < 16; gap mode with `cfg_size` < 192; gap mode with either width 0. A rejected configuration sets `done`, `err` and `irq` on the cycle after `start`, keeps `busy` low, and issues no memory request.
- R9: When the last write is accepted, `busy` falls, sticky `done` rises, and `irq` is high for exactly that one cycle. `done` and `busy` are never high together.
- R10: A `clr_done` pulse clears `done`. An accepted `start` clears both `done` and `err`.
- R11: While a valid is high and its ready is low, the valid stays high and its address and data stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_addr | input | 32 | Source start byte address (16-byte aligned) |
| cfg_dst_addr | input | 32 | Destination start byte address (16-byte aligned) |
| cfg_size | input | 24 | Bytes to copy, excluding gaps |
| cfg_in_width | input | 16 | Input line length in 16-byte units |
| cfg_in_gap | input | 16 | Input skip after each line, in 16-byte units |
| cfg_out_width | input | 16 | Output line length in 16-byte units |
| cfg_out_gap | input | 16 | Output skip after each line, in 16-byte units |
| cfg_gap_en | input | 1 | 1 = apply line widths and gaps, 0 = contiguous |
| start | input | 1 | Begin a copy (accepted only when idle) |
| clr_done | input | 1 | Clear the sticky done flag |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read request byte address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rready | output | 1 | Engine can take read data |
| rd_rdata | input | 128 | Read data beat |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 128 | Write data beat |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Last start was refused |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the ones where the two sides wrap at different points. An input line may end in the middle of an output line, or one side may reach a gap on the same beat as the other side's gap. These only matter while the memory is also stalling each channel at random points.

The stimulus draws independent widths and gaps for each side, together with beat counts that span several lines, and applies random stalls on all three channels. This makes misaligned and coinciding wraps appear many times over. Directed cases cover the smallest sizes that are accepted and the largest that are refused, a zero width, a size that is not a multiple of 16, and a `start` pulse that arrives while a copy is still running.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_DATA = 2'd2,
    ST_WR      = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/sce_cfg_check.sv
module sce_cfg_check #(
  parameter int SIZE_W     = 24,
  parameter int DIM_W      = 16,
  parameter int OFS        = 4,
  parameter int MIN_CONTIG = 16,
  parameter int MIN_GAP    = 192
) (
  input  logic [SIZE_W-1:0]     size,
  input  logic [DIM_W-1:0]      in_width,
  input  logic [DIM_W-1:0]      out_width,
  input  logic                  gap_en,
  output logic                  bad,
  output logic [SIZE_W-OFS-1:0] beats
);
  localparam int BEAT_W = SIZE_W - OFS;

  logic small_contig, small_gap, zero_width;

  always_comb begin
    beats        = size[SIZE_W-1:OFS];
    small_contig = (size < SIZE_W'(MIN_CONTIG));
    small_gap    = (size < SIZE_W'(MIN_GAP));
    zero_width   = (in_width == '0) || (out_width == '0);
    if (gap_en) bad = small_gap || zero_width;
    else        bad = small_contig;
  end

  // R8: an accepted configuration always has at least one whole beat to move
  always_comb begin
    if (!bad) assert (beats != BEAT_W'(0)) else $error("AST_BEATS_NONZERO"); // R8
  end
endmodule

// File: rtl/sce_addr_walker.sv
module sce_addr_walker #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16,
  parameter int OFS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  gap,
  input  logic              gap_en,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] UNIT = ADDR_W'(1) << OFS;

  logic [ADDR_W-1:0] addr_q;
  logic [DIM_W-1:0]  pos_q, width_q, gap_q;
  logic              gap_en_q;
  logic              line_end;
  logic [ADDR_W-1:0] skip;

  assign line_end = gap_en_q && (pos_q == width_q - DIM_W'(1));
  assign skip     = (ADDR_W'(gap_q) + ADDR_W'(1)) << OFS;
  assign addr     = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      pos_q    <= '0;
      width_q  <= '0;
      gap_q    <= '0;
      gap_en_q <= 1'b0;
    end else if (load) begin
      addr_q   <= base;
      pos_q    <= '0;
      width_q  <= width;
      gap_q    <= gap;
      gap_en_q <= gap_en;
    end else if (step) begin
      if (line_end) begin
        addr_q <= addr_q + skip;
        pos_q  <= '0;
      end else begin
        addr_q <= addr_q + UNIT;
        if (gap_en_q) pos_q <= pos_q + DIM_W'(1);
      end
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap_en_q |-> (pos_q < width_q)); // R5
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q[OFS-1:0] == $past(addr_q[OFS-1:0]))); // R4
endmodule

// File: rtl/strided_copy_engine.sv
module strided_copy_engine #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 128,
  parameter int SIZE_W     = 24,
  parameter int DIM_W      = 16,
  parameter int MIN_CONTIG = 16,
  parameter int MIN_GAP    = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [DIM_W-1:0]  cfg_in_width,
  input  logic [DIM_W-1:0]  cfg_in_gap,
  input  logic [DIM_W-1:0]  cfg_out_width,
  input  logic [DIM_W-1:0]  cfg_out_gap,
  input  logic              cfg_gap_en,
  input  logic              start,
  input  logic              clr_done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rvalid,
  output logic              rd_rready,
  input  logic [DATA_W-1:0] rd_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              irq
);
  import sce_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int OFS    = $clog2(BYTES);
  localparam int BEAT_W = SIZE_W - OFS;

  xfer_state_e       state_q;
  logic [BEAT_W-1:0] left_q, beats;
  logic [DATA_W-1:0] data_q;
  logic              bad, accept, rd_fire, rdat_fire, wr_fire, finish;
  logic              done_q, err_q, irq_q;

  sce_cfg_check #(
    .SIZE_W(SIZE_W), .DIM_W(DIM_W), .OFS(OFS),
    .MIN_CONTIG(MIN_CONTIG), .MIN_GAP(MIN_GAP)
  ) u_check (
    .size(cfg_size), .in_width(cfg_in_width), .out_width(cfg_out_width),
    .gap_en(cfg_gap_en), .bad(bad), .beats(beats)
  );

  assign accept    = start && (state_q == ST_IDLE);
  assign rd_fire   = rd_valid && rd_ready;
  assign rdat_fire = rd_rvalid && rd_rready;
  assign wr_fire   = wr_valid && wr_ready;
  assign finish    = wr_fire && (left_q == BEAT_W'(1));

  sce_addr_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .OFS(OFS)) u_src_walk (
    .clk(clk), .rst_n(rst_n), .load(accept && !bad), .step(wr_fire),
    .base(cfg_src_addr), .width(cfg_in_width), .gap(cfg_in_gap),
    .gap_en(cfg_gap_en), .addr(rd_addr)
  );

  sce_addr_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .OFS(OFS)) u_dst_walk (
    .clk(clk), .rst_n(rst_n), .load(accept && !bad), .step(wr_fire),
    .base(cfg_dst_addr), .width(cfg_out_width), .gap(cfg_out_gap),
    .gap_en(cfg_gap_en), .addr(wr_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && !bad) begin
          state_q <= ST_RD_REQ;
          left_q  <= beats;
        end
        ST_RD_REQ:  if (rd_fire) state_q <= ST_RD_DATA;
        ST_RD_DATA: if (rdat_fire) begin
          data_q  <= rd_rdata;
          state_q <= ST_WR;
        end
        ST_WR: if (wr_fire) begin
          left_q  <= left_q - BEAT_W'(1);
          state_q <= finish ? ST_IDLE : ST_RD_REQ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (accept) begin
        done_q <= bad;
        err_q  <= bad;
        irq_q  <= bad;
      end else if (finish) begin
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end else if (clr_done) begin
        done_q <= 1'b0;
      end
    end
  end

  assign rd_valid  = (state_q == ST_RD_REQ);
  assign rd_rready = (state_q == ST_RD_DATA);
  assign wr_valid  = (state_q == ST_WR);
  assign wr_data   = data_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign irq       = irq_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R11
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rd_valid && !wr_valid)); // R8
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done)); // R2
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, rd_rready, wr_valid})); // R11
endmodule

// File: tb/strided_copy_engine_bench.sv
module strided_copy_engine_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [23:0]  cfg_size = '0;
  logic [15:0]  cfg_in_width = '0, cfg_in_gap = '0, cfg_out_width = '0, cfg_out_gap = '0;
  logic         cfg_gap_en = 1'b0, start = 1'b0, clr_done = 1'b0;
  logic         rd_valid, rd_ready = 1'b0, rd_rvalid = 1'b0, rd_rready;
  logic [31:0]  rd_addr, wr_addr;
  logic [127:0] rd_rdata = '0, wr_data;
  logic         wr_valid, wr_ready = 1'b0, busy, done, err, irq;

  int checks = 0, errors = 0;
  int nrd = 0, nwr = 0, traffic = 0;
  logic [31:0]  rd_log [0:255];
  logic [31:0]  wa_log [0:255];
  logic [127:0] wd_log [0:255];
  logic         pend = 1'b0;
  logic [31:0]  paddr = '0;

  always #4 clk = ~clk;

  strided_copy_engine u_strided_copy_engine (
    .clk(clk), .rst_n(rst_n), .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_size(cfg_size), .cfg_in_width(cfg_in_width), .cfg_in_gap(cfg_in_gap),
    .cfg_out_width(cfg_out_width), .cfg_out_gap(cfg_out_gap), .cfg_gap_en(cfg_gap_en),
    .start(start), .clr_done(clr_done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rready(rd_rready), .rd_rdata(rd_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err), .irq(irq)
  );

  function automatic logic [127:0] mkdata(input logic [31:0] a);
    return {a, ~a, a ^ 32'h5a5a_5a5a, a + 32'd7};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int w,
                                           input int g, input bit ge, input int k);
    if (!ge) return base + 32'(16 * k);
    return base + 32'(16 * ((k / w) * (w + g) + (k % w)));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: random stalls on all channels, one read outstanding
  initial begin
    forever begin
      @(negedge clk);
      rd_ready = 1'b0; rd_rvalid = 1'b0; wr_ready = 1'b0;
      if (rd_valid || wr_valid) traffic++;
      if (pend) begin
        if ($urandom % 3 != 0) begin
          rd_rvalid = 1'b1; rd_rdata = mkdata(paddr); pend = 1'b0;
        end
      end else if (rd_valid && ($urandom % 3 != 0)) begin
        rd_ready = 1'b1; pend = 1'b1; paddr = rd_addr;
        if (nrd < 256) rd_log[nrd] = rd_addr;
        nrd++;
      end
      if (wr_valid && ($urandom % 3 != 0)) begin
        wr_ready = 1'b1;
        if (nwr < 256) begin wa_log[nwr] = wr_addr; wd_log[nwr] = wr_data; end
        nwr++;
      end
    end
  end

  task automatic run_xfer(input logic [31:0] src, input logic [31:0] dst, input int size,
                          input int iw, input int ig, input int ow, input int og,
                          input bit ge, input bit poke);
    int beats, irq_cnt, cyc;
    bit ok_a, ok_w, ok_d, irq_at_done;
    beats = size / 16;
    nrd = 0; nwr = 0; irq_cnt = 0;
    @(negedge clk);
    cfg_src_addr = src; cfg_dst_addr = dst; cfg_size = 24'(size);
    cfg_in_width = 16'(iw); cfg_in_gap = 16'(ig); cfg_out_width = 16'(ow);
    cfg_out_gap = 16'(og); cfg_gap_en = ge; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !err, "R2", "busy after start", {busy, done, err}, 3'b100);
    chk(!done, "R10", "start clears done", done, 0);
    if (poke) begin
      @(negedge clk);
      cfg_src_addr = 32'h0dd0_0000; cfg_size = 24'd16; cfg_gap_en = ~ge; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (irq) irq_cnt++;
      @(negedge clk);
      cyc++;
    end
    irq_at_done = irq;
    if (irq) irq_cnt++;
    chk(done && !busy, "R9", "done set, busy clear", {done, busy}, 2'b10);
    chk(nrd == beats, "R3", "read beats", nrd, beats);
    chk(nwr == beats, "R3", "written beats", nwr, beats);
    ok_a = 1; ok_w = 1; ok_d = 1;
    for (int k = 0; k < beats && k < 256; k++) begin
      if (rd_log[k] != exp_addr(src, iw, ig, ge, k)) ok_a = 0;
      if (wa_log[k] != exp_addr(dst, ow, og, ge, k)) ok_w = 0;
      if (wd_log[k] != mkdata(exp_addr(src, iw, ig, ge, k))) ok_d = 0;
    end
    chk(ok_a, ge ? "R5" : "R4", "read address sequence", ok_a, 1);
    chk(ok_w, ge ? "R6" : "R4", "write address sequence", ok_w, 1);
    chk(ok_d, "R7", "written data", ok_d, 1);
    chk(irq_at_done && irq_cnt == 1, "R9", "irq pulse count", irq_cnt, 1);
    @(negedge clk);
    chk(done && !irq, "R9", "done sticky, irq low", {done, irq}, 2'b10);
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk(!done, "R10", "clr_done clears done", done, 0);
  endtask

  task automatic run_bad(input int size, input int iw, input int ow, input bit ge, input string what);
    @(negedge clk);
    cfg_size = 24'(size); cfg_in_width = 16'(iw); cfg_out_width = 16'(ow);
    cfg_in_gap = 16'd1; cfg_out_gap = 16'd2; cfg_gap_en = ge; start = 1'b1;
    traffic = 0;
    @(negedge clk);
    start = 1'b0;
    chk(done && err && irq && !busy, "R8", what, {done, err, irq, busy}, 4'b1110);
    repeat (4) @(negedge clk);
    chk(traffic == 0 && err && !irq, "R8", {what, " no traffic"}, traffic, 0);
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, irq, rd_valid, wr_valid} == 6'b0, "R1", "reset outputs",
        {busy, done, err, irq, rd_valid, wr_valid}, 0);

    // directed corners
    run_xfer(32'h1000_0000, 32'h2000_0000, 16, 3, 3, 3, 3, 1'b0, 1'b0);   // R4 min contiguous
    run_xfer(32'h1000_0100, 32'h2000_0800, 5 * 16 + 7, 9, 9, 9, 9, 1'b0, 1'b0); // R3 remainder
    run_xfer(32'h3000_0000, 32'h4000_0000, 192, 4, 2, 3, 0, 1'b1, 1'b0);  // R5 R6 min gap size
    run_xfer(32'h3000_1000, 32'h4000_2000, 14 * 16, 1, 5, 7, 1, 1'b1, 1'b0); // R6 width 1
    run_xfer(32'h5000_0000, 32'h6000_0000, 20 * 16, 4, 1, 5, 2, 1'b1, 1'b1); // R2 start while busy
    run_bad(15, 1, 1, 1'b0, "contiguous size 15");
    run_bad(176, 4, 4, 1'b1, "gap size 176");
    run_bad(400, 0, 4, 1'b1, "in width 0");
    run_bad(400, 4, 0, 1'b1, "out width 0");
    run_xfer(32'h7000_0000, 32'h7100_0000, 12 * 16, 2, 0, 6, 0, 1'b1, 1'b0); // R10 err cleared
    chk(!err, "R10", "start clears err", err, 0);

    for (int t = 0; t < 24; t++) begin
      bit ge;
      int beats;
      ge = 1'($urandom % 2);
      beats = ge ? 12 + int'($urandom % 29) : 1 + int'($urandom % 40);
      run_xfer({$urandom % 32'h0fff_ffff, 4'h0}, {$urandom % 32'h0fff_ffff, 4'h0},
               beats * 16 + int'($urandom % 16),
               1 + int'($urandom % 6), int'($urandom % 5),
               1 + int'($urandom % 6), int'($urandom % 5), ge, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule